// File: doc/BRIEF.md
# Serial Display Command Receiver

This block sits between a host's three-wire serial link and the memories and control registers of a dot-matrix character display. The host pulls the active-low select line low, then clocks bits in on the rising edge of a shift clock, least significant bit first. Every eight bits form one byte. The serial lines run asynchronously to the system clock. Each line passes through a two-flop synchroniser, and shift-clock rising edges are detected in the system clock domain.

The first byte after select falls is a command. Its upper nibble picks the operation. Register commands update the digit-count code, the duty code, the two general port bits or the all-lights flags at once. Memory commands load a start address and enter a streaming mode. In that mode each following byte becomes a write to one of three memories: a 16-entry character-code memory, an 8-entry 35-bit pattern memory, or a 16-entry 2-bit symbol memory. The address steps forward after each write and wraps around. A pattern entry is assembled from five column bytes and is written in one strobe. Raising select ends the stream and discards any partial byte.

The decoder is a four-state machine:
- `ST_CMD` waits for a command byte.
- `ST_CODE`, `ST_PAT` and `ST_SYM` are the streaming modes.
- A command byte with opcode 1, 2 or 3 moves from `ST_CMD` to `ST_CODE`, `ST_PAT` or `ST_SYM` respectively.
- Any other opcode stays in `ST_CMD`.
- The streaming states hold on data bytes.
- Every state returns to `ST_CMD` whenever select is high.

Top module: `dispcmd_rx`

## Requirements
- R1: While `ser_csn` is low, a bit is taken from `ser_dat` on each rising edge of `ser_clk`. The first bit is byte bit 0 and the eighth is bit 7. Every completed byte is acted on without any other strobe.
- R2: `ser_csn` high discards a partially shifted byte and ends any streaming mode. The first complete byte after `ser_csn` falls again is decoded as a command.
- R3: In a command byte, opcode = bits [7:4] as a number: 1 = character-code write, 2 = pattern write, 3 = symbol write, 4 = port set, 5 = duty set, 6 = digit-count set, 7 = all-lights set. Any other opcode changes no register and starts no stream, so the next byte is again a command.
- R4: After opcode 1, bits [3:0] are the start address. Each following byte is written to `code_addr` = current address with `code_data` = the byte, and the address then increments and wraps from 15 to 0.
- R5: After opcode 2, bits [2:0] are the start address and bit 3 is ignored. Each group of five following bytes fills columns k = 0..4. Bit r (r = 0..6) of column byte k goes to `pat_data` bit 5*r+k, and bit 7 is ignored. One write happens after the fifth byte, and the address then increments and wraps from 7 to 0. An incomplete group leaves no write.
- R6: After opcode 3, addressing is as in R4. `sym_data` = bits [1:0] of each data byte, and the other bits are ignored.
- R7: Opcode 4 sets `port_out` = bits [1:0] (`port_out[0]` = bit 0). Opcode 5 sets `duty_code` = bits [2:0]. Opcode 6 sets `digit_code` = bits [2:0]. Bit 3 is ignored in all three.
- R8: Opcode 7 sets `lamp_off` = bit 0 and `lamp_on` = bit 1.
- R9: Reset gives these values: `digit_code` = 0, `duty_code` = 0, `port_out` = 0, `lamp_off` = 1, `lamp_on` = 0. All memory addresses are 0 and no write strobe is active.
- R10: Each write strobe lasts one clock. At most one strobe is active at a time, and each one follows a completed byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_dat | input | 1 | Serial data, asynchronous |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_csn | input | 1 | Active-low select, asynchronous |
| code_we | output | 1 | Character-code memory write strobe |
| code_addr | output | 4 | Character-code memory write address |
| code_data | output | 8 | Character code to write |
| pat_we | output | 1 | Pattern memory write strobe |
| pat_addr | output | 3 | Pattern memory write address |
| pat_data | output | 35 | Assembled 5x7 pattern |
| sym_we | output | 1 | Symbol memory write strobe |
| sym_addr | output | 4 | Symbol memory write address |
| sym_data | output | 2 | Symbol bits to write |
| digit_code | output | 3 | Digit-count code |
| duty_code | output | 3 | Duty code |
| port_out | output | 2 | General output port bits |
| lamp_off | output | 1 | All-lights-off request |
| lamp_on | output | 1 | All-lights-on request |

## Verification
A bit counter that drifts out of step shows up on the very next byte. Its write lands at an unexpected address or with a rotated value, or a register changes that should not. A state machine stuck in a streaming mode turns the next command into a memory write with its own strobe, and an early exit turns data into register updates. In both cases the outputs go wrong within the same byte. A pattern column counter that is off by one misplaces dots inside the 35-bit word, or shifts the write strobe by one byte. This is visible at the first commit after the fault.

// File: rtl/dispcmd_pkg.sv
package dispcmd_pkg;
    localparam int BYTE_W  = 8;
    localparam int CODE_AW = 4;
    localparam int PAT_AW  = 3;
    localparam int COLS    = 5;
    localparam int ROWS    = 7;
    localparam int PAT_W   = COLS * ROWS;
    localparam int SYM_W   = 2;
    localparam int REG_W   = 3;
    localparam int PORT_W  = 2;

    typedef enum logic [1:0] {
        ST_CMD,
        ST_CODE,
        ST_PAT,
        ST_SYM
    } dec_state_t;

    localparam logic [3:0] OP_CODE  = 4'h1;
    localparam logic [3:0] OP_PAT   = 4'h2;
    localparam logic [3:0] OP_SYM   = 4'h3;
    localparam logic [3:0] OP_PORT  = 4'h4;
    localparam logic [3:0] OP_DUTY  = 4'h5;
    localparam logic [3:0] OP_DIGIT = 4'h6;
    localparam logic [3:0] OP_LAMP  = 4'h7;
endpackage

// File: rtl/dispcmd_sync.sv
module dispcmd_sync #(
    parameter int                N       = 3,
    parameter int                STAGES  = 2,
    parameter logic [N-1:0]      RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_async,
    output logic [N-1:0] d_sync
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
            else        chain <= {chain[STAGES-2:0], d_async[i]};
        end
        assign d_sync[i] = chain[STAGES-1];
    end
endmodule

// File: rtl/dispcmd_deser.sv
module dispcmd_deser #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sclk,
    input  logic         sdat,
    input  logic         csn,
    output logic         byte_vld,
    output logic [W-1:0] byte_q
);
    localparam int CNT_W = $clog2(W);

    logic             sclk_d;
    logic [CNT_W-1:0] cnt;
    logic [W-1:0]     shreg;
    logic             rise;

    assign rise = sclk & ~sclk_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d   <= 1'b0;
            cnt      <= '0;
            shreg    <= '0;
            byte_vld <= 1'b0;
            byte_q   <= '0;
        end else begin
            sclk_d   <= sclk;
            byte_vld <= 1'b0;
            if (csn) begin
                cnt <= '0;
            end else if (rise) begin
                shreg <= {sdat, shreg[W-1:1]};
                if (cnt == CNT_W'(W - 1)) begin
                    cnt      <= '0;
                    byte_vld <= 1'b1;
                    byte_q   <= {sdat, shreg[W-1:1]};
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dispcmd_dec.sv
module dispcmd_dec
    import dispcmd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               csn,
    input  logic               byte_vld,
    input  logic [BYTE_W-1:0]  byte_q,
    output logic               code_we,
    output logic [CODE_AW-1:0] code_addr,
    output logic [BYTE_W-1:0]  code_data,
    output logic               pat_we,
    output logic [PAT_AW-1:0]  pat_addr,
    output logic [PAT_W-1:0]   pat_data,
    output logic               sym_we,
    output logic [CODE_AW-1:0] sym_addr,
    output logic [SYM_W-1:0]   sym_data,
    output logic [REG_W-1:0]   digit_code,
    output logic [REG_W-1:0]   duty_code,
    output logic [PORT_W-1:0]  port_out,
    output logic               lamp_off,
    output logic               lamp_on
);
    localparam int COL_W = $clog2(COLS);

    dec_state_t         state, state_nxt;
    logic [3:0]         op;
    logic [CODE_AW-1:0] code_ptr, sym_ptr;
    logic [PAT_AW-1:0]  pat_ptr;
    logic [COL_W-1:0]   col;
    logic [PAT_W-1:0]   pat_buf, pat_merge;

    assign op = byte_q[BYTE_W-1:BYTE_W-4];

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_CMD: begin
                if (byte_vld) begin
                    if (op == OP_CODE)     state_nxt = ST_CODE;
                    else if (op == OP_PAT) state_nxt = ST_PAT;
                    else if (op == OP_SYM) state_nxt = ST_SYM;
                end
            end
            ST_CODE, ST_PAT, ST_SYM: state_nxt = state;
        endcase
        if (csn) state_nxt = ST_CMD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_CMD;
        else        state <= state_nxt;
    end

    always_comb begin
        pat_merge = pat_buf;
        for (int r = 0; r < ROWS; r++)
            pat_merge[r * COLS + int'(col)] = byte_q[r];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_we    <= 1'b0;
            code_addr  <= '0;
            code_data  <= '0;
            pat_we     <= 1'b0;
            pat_addr   <= '0;
            pat_data   <= '0;
            sym_we     <= 1'b0;
            sym_addr   <= '0;
            sym_data   <= '0;
            digit_code <= '0;
            duty_code  <= '0;
            port_out   <= '0;
            lamp_off   <= 1'b1;
            lamp_on    <= 1'b0;
            code_ptr   <= '0;
            sym_ptr    <= '0;
            pat_ptr    <= '0;
            col        <= '0;
            pat_buf    <= '0;
        end else begin
            code_we <= 1'b0;
            pat_we  <= 1'b0;
            sym_we  <= 1'b0;
            if (csn) begin
                col <= '0;
            end else if (byte_vld) begin
                unique case (state)
                    ST_CMD: begin
                        case (op)
                            OP_CODE:  code_ptr   <= byte_q[CODE_AW-1:0];
                            OP_PAT: begin
                                pat_ptr <= byte_q[PAT_AW-1:0];
                                col     <= '0;
                            end
                            OP_SYM:   sym_ptr    <= byte_q[CODE_AW-1:0];
                            OP_PORT:  port_out   <= byte_q[PORT_W-1:0];
                            OP_DUTY:  duty_code  <= byte_q[REG_W-1:0];
                            OP_DIGIT: digit_code <= byte_q[REG_W-1:0];
                            OP_LAMP: begin
                                lamp_off <= byte_q[0];
                                lamp_on  <= byte_q[1];
                            end
                            default: ;
                        endcase
                    end
                    ST_CODE: begin
                        code_we   <= 1'b1;
                        code_addr <= code_ptr;
                        code_data <= byte_q;
                        code_ptr  <= code_ptr + 1'b1;
                    end
                    ST_PAT: begin
                        pat_buf <= pat_merge;
                        if (col == COL_W'(COLS - 1)) begin
                            pat_we   <= 1'b1;
                            pat_addr <= pat_ptr;
                            pat_data <= pat_merge;
                            pat_ptr  <= pat_ptr + 1'b1;
                            col      <= '0;
                        end else begin
                            col <= col + 1'b1;
                        end
                    end
                    ST_SYM: begin
                        sym_we   <= 1'b1;
                        sym_addr <= sym_ptr;
                        sym_data <= byte_q[SYM_W-1:0];
                        sym_ptr  <= sym_ptr + 1'b1;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/dispcmd_rx.sv
module dispcmd_rx
    import dispcmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_dat,
    input  logic               ser_clk,
    input  logic               ser_csn,
    output logic               code_we,
    output logic [CODE_AW-1:0] code_addr,
    output logic [BYTE_W-1:0]  code_data,
    output logic               pat_we,
    output logic [PAT_AW-1:0]  pat_addr,
    output logic [PAT_W-1:0]   pat_data,
    output logic               sym_we,
    output logic [CODE_AW-1:0] sym_addr,
    output logic [SYM_W-1:0]   sym_data,
    output logic [REG_W-1:0]   digit_code,
    output logic [REG_W-1:0]   duty_code,
    output logic [PORT_W-1:0]  port_out,
    output logic               lamp_off,
    output logic               lamp_on
);
    logic [2:0]        s_lines;
    logic              byte_vld;
    logic [BYTE_W-1:0] byte_q;

    dispcmd_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({ser_csn, ser_clk, ser_dat}),
        .d_sync  (s_lines)
    );

    dispcmd_deser #(.W(BYTE_W)) u_deser (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk     (s_lines[1]),
        .sdat     (s_lines[0]),
        .csn      (s_lines[2]),
        .byte_vld (byte_vld),
        .byte_q   (byte_q)
    );

    dispcmd_dec u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .csn        (s_lines[2]),
        .byte_vld   (byte_vld),
        .byte_q     (byte_q),
        .code_we    (code_we),
        .code_addr  (code_addr),
        .code_data  (code_data),
        .pat_we     (pat_we),
        .pat_addr   (pat_addr),
        .pat_data   (pat_data),
        .sym_we     (sym_we),
        .sym_addr   (sym_addr),
        .sym_data   (sym_data),
        .digit_code (digit_code),
        .duty_code  (duty_code),
        .port_out   (port_out),
        .lamp_off   (lamp_off),
        .lamp_on    (lamp_on)
    );
endmodule

// File: rtl/dispcmd_rx_chk.sv
module dispcmd_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       byte_vld,
    input logic       code_we,
    input logic       pat_we,
    input logic       sym_we,
    input logic [2:0] digit_code,
    input logic [2:0] duty_code,
    input logic [1:0] port_out,
    input logic       lamp_off,
    input logic       lamp_on
);
    logic any_we;
    assign any_we = code_we | pat_we | sym_we;

    assert_single_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({code_we, pat_we, sym_we}));

    assert_write_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        any_we |=> !any_we);

    assert_write_after_byte_R1: assert property (@(posedge clk) disable iff (!rst_n)
        any_we |-> $past(byte_vld));

    assert_regs_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(byte_vld) |-> $stable({digit_code, duty_code, port_out, lamp_off, lamp_on}));
endmodule

bind dispcmd_rx dispcmd_rx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_vld   (byte_vld),
    .code_we    (code_we),
    .pat_we     (pat_we),
    .sym_we     (sym_we),
    .digit_code (digit_code),
    .duty_code  (duty_code),
    .port_out   (port_out),
    .lamp_off   (lamp_off),
    .lamp_on    (lamp_on)
);

// File: tb/sim_dispcmd_rx.sv
`timescale 1ns/1ps
module sim_dispcmd_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_dat = 1'b0, ser_clk = 1'b0, ser_csn = 1'b1;
    logic        code_we, pat_we, sym_we, lamp_off, lamp_on;
    logic [3:0]  code_addr, sym_addr;
    logic [7:0]  code_data;
    logic [2:0]  pat_addr, digit_code, duty_code;
    logic [34:0] pat_data;
    logic [1:0]  sym_data, port_out;

    int n_chk = 0, n_bad = 0;
    int n_code = 0, n_pat = 0, n_sym = 0;
    logic [7:0]  code_mem [16];
    logic [34:0] pat_mem [8];
    logic [1:0]  sym_mem [16];

    always #2 clk = ~clk;

    dispcmd_rx u0 (.*);

    // byte, digit, duty, port, lamp_off, lamp_on (cumulative expected state)
    localparam logic [17:0] TBL [12] = '{
        {8'h41, 3'd0, 3'd0, 2'd1, 1'b1, 1'b0},
        {8'h42, 3'd0, 3'd0, 2'd2, 1'b1, 1'b0},
        {8'h57, 3'd0, 3'd7, 2'd2, 1'b1, 1'b0},
        {8'h5D, 3'd0, 3'd5, 2'd2, 1'b1, 1'b0},
        {8'h63, 3'd3, 3'd5, 2'd2, 1'b1, 1'b0},
        {8'h6F, 3'd7, 3'd5, 2'd2, 1'b1, 1'b0},
        {8'h72, 3'd7, 3'd5, 2'd2, 1'b0, 1'b1},
        {8'h73, 3'd7, 3'd5, 2'd2, 1'b1, 1'b1},
        {8'h70, 3'd7, 3'd5, 2'd2, 1'b0, 1'b0},
        {8'h0E, 3'd7, 3'd5, 2'd2, 1'b0, 1'b0},
        {8'hF3, 3'd7, 3'd5, 2'd2, 1'b0, 1'b0},
        {8'h44, 3'd7, 3'd5, 2'd0, 1'b0, 1'b0}
    };

    always @(negedge clk) begin
        if (rst_n) begin
            if (code_we) begin code_mem[code_addr] = code_data; n_code++; end
            if (pat_we)  begin pat_mem[pat_addr]   = pat_data;  n_pat++;  end
            if (sym_we)  begin sym_mem[sym_addr]   = sym_data;  n_sym++;  end
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            ser_dat = b[i];
            tick(3);
            ser_clk = 1'b1;
            tick(4);
            ser_clk = 1'b0;
            tick(1);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        send_bits(b, 8);
    endtask

    task automatic cs_lo;
        ser_csn = 1'b0;
        tick(6);
    endtask

    task automatic cs_hi;
        tick(10);
        ser_csn = 1'b1;
        tick(8);
    endtask

    function automatic logic [34:0] pat_of(input logic [39:0] cols);
        logic [34:0] p = '0;
        for (int k = 0; k < 5; k++)
            for (int r = 0; r < 7; r++)
                p[5 * r + k] = cols[8 * k + r];
        return p;
    endfunction

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        tick(10);
        // R9: reset state
        check("R9 digit", digit_code, 0);
        check("R9 duty", duty_code, 0);
        check("R9 port", port_out, 0);
        check("R9 lamp_off", lamp_off, 1);
        check("R9 lamp_on", lamp_on, 0);
        check("R9 strobes", {code_we, pat_we, sym_we}, 0);
        rst_n = 1'b1;
        tick(4);

        // R7 R8 R3: register command table
        for (int i = 0; i < 12; i++) begin
            cs_lo();
            send_byte(TBL[i][17:10]);
            cs_hi();
            check($sformatf("R7 digit entry %0d", i), digit_code, TBL[i][9:7]);
            check($sformatf("R7 duty entry %0d", i), duty_code, TBL[i][6:4]);
            check($sformatf("R7 port entry %0d", i), port_out, TBL[i][3:2]);
            check($sformatf("R8 lamps entry %0d", i), {lamp_off, lamp_on}, TBL[i][1:0]);
        end
        check("R3 no writes from register commands", n_code + n_pat + n_sym, 0);

        // R4 R1: character-code stream with wrap
        cs_lo();
        send_byte(8'h1E); send_byte(8'hA5); send_byte(8'h3C); send_byte(8'h77);
        cs_hi();
        check("R4 count", n_code, 3);
        check("R4 addr14", code_mem[14], 8'hA5);
        check("R4 addr15", code_mem[15], 8'h3C);
        check("R4 wrap addr0", code_mem[0], 8'h77);

        // R6: symbol stream, upper bits ignored
        cs_lo();
        send_byte(8'h35); send_byte(8'hFE); send_byte(8'h01);
        cs_hi();
        check("R6 count", n_sym, 2);
        check("R6 addr5", sym_mem[5], 2'b10);
        check("R6 addr6", sym_mem[6], 2'b01);

        // R5: pattern assembly, b3 ignored in address, b7 ignored in data
        cs_lo();
        send_byte(8'h2A);
        send_byte(8'h7F); send_byte(8'h00); send_byte(8'h01); send_byte(8'h40);
        check("R5 no write before fifth", n_pat, 0);
        send_byte(8'h81);
        send_byte(8'h01); send_byte(8'h00); send_byte(8'h00); send_byte(8'h00); send_byte(8'h00);
        cs_hi();
        check("R5 count", n_pat, 2);
        check("R5 addr2", pat_mem[2], pat_of({8'h01, 8'h40, 8'h01, 8'h00, 8'h7F}));
        check("R5 addr3", pat_mem[3], 35'h1);

        // R5: pattern address wrap 7 -> 0
        cs_lo();
        send_byte(8'h27);
        for (int k = 0; k < 5; k++) send_byte(k == 0 ? 8'h01 : 8'h00);
        for (int k = 0; k < 5; k++) send_byte(k == 4 ? 8'h40 : 8'h00);
        cs_hi();
        check("R5 addr7", pat_mem[7], 35'h1);
        check("R5 wrap addr0", pat_mem[0], 35'h1 << 34);

        // R5 R2: incomplete group leaves no write; column count restarts
        cs_lo();
        send_byte(8'h20);
        for (int k = 0; k < 4; k++) send_byte(8'h7F);
        cs_hi();
        check("R5 partial no write", n_pat, 4);
        cs_lo();
        send_byte(8'h21);
        for (int k = 0; k < 4; k++) send_byte(8'h00);
        check("R2 column restart no early write", n_pat, 4);
        send_byte(8'h02);
        cs_hi();
        check("R2 column restart write", n_pat, 5);
        check("R5 addr1", pat_mem[1], 35'h1 << 9);

        // R2: partial byte dropped at select rise
        cs_lo();
        send_bits(8'h1F, 5);
        cs_hi();
        check("R2 partial byte no effect", duty_code, 3'd5);
        cs_lo();
        send_byte(8'h52);
        cs_hi();
        check("R2 framing restarts", duty_code, 3'd2);

        // R2: select rise ends stream; next byte is a command
        cs_lo();
        send_byte(8'h10); send_byte(8'h11);
        cs_hi();
        cs_lo();
        send_byte(8'h56);
        cs_hi();
        check("R2 stream write", code_mem[0], 8'h11);
        check("R2 code count", n_code, 4);
        check("R2 byte after reselect is command", duty_code, 3'd6);

        // R3: unknown opcode keeps command mode within one selection
        cs_lo();
        send_byte(8'h00); send_byte(8'h61);
        cs_hi();
        check("R3 unknown then digit", digit_code, 3'd1);
        check("R3 unknown no writes", n_code + n_sym, 6);

        summary();
        $finish;
    end
endmodule